// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a processor load/store port and a lower-level memory. It accepts doubleword (8-byte) reads and writes on a 40-bit physical address and holds 64 KB of data as 512 sets of two ways. Each way carries a valid flag, a dirty flag, a 25-bit tag and a 64-byte line. A request that hits finishes without stalling. A request that misses stalls the processor port while the controller picks a victim, writes it back if it holds modified data, and then fetches the new line. After that the original request completes against the installed line.

Stores follow a write-back, write-allocate policy. A store that hits changes only the cached copy and marks it dirty. A store that misses first brings the whole line in, then merges the store into it. Memory only sees whole-line traffic: line write-backs and line fetches. Each transfer uses a request that is held until a single-cycle acknowledge, and the memory may take any number of cycles to answer.

Top module: `dcache2w`

## Requirements
- R1: Address fields are byte offset [5:0], set index [14:6] (512 sets) and tag [39:15]. Bits [5:3] pick the doubleword within the line. Two addresses with the same tag but different index occupy different sets.
- R2: A read that hits keeps `cpu_ready` high. It raises `cpu_resp_valid` on the next cycle, with the addressed doubleword on `cpu_resp_rdata`, and issues no memory request.
- R3: A write that hits updates only the bytes whose `cpu_req_be` bit is set (bit i covers data bits 8i+7..8i). It completes with a response on the next cycle and makes no memory access.
- R4: After reset every way is invalid, so the first access to any address is a miss that fetches its line.
- R5: Each set keeps one replacement bit that names the least recently used way. Every hit and every fill points it at the other way. On a miss with both ways valid, the way it names is evicted.
- R6: If a set has an invalid way, a miss fills that way and evicts no valid line.
- R7: If the victim is dirty, its whole line is written to memory before the refill read starts. The write goes to the address made of the victim's tag, the set index and a zero offset.
- R8: A clean victim is discarded without any memory write.
- R9: A read miss fetches the whole line, installs it, and returns the requested doubleword. `cpu_ready` stays low from the cycle after the miss is accepted until the response.
- R10: A write miss fetches and installs the line, merges the store bytes into it, and marks the line dirty. The merged data appears in that line's later write-back.
- R11: `mem_req_valid`, `mem_req_write` and `mem_req_addr` stay steady from the start of a memory request until the cycle `mem_ack` is sampled. Any acknowledge delay of one or more cycles is accepted.
- R12: Every accepted request gets exactly one single-cycle `cpu_resp_valid`. After a refill acknowledge, that response comes two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 40 | Physical byte address |
| cpu_req_wdata | input | 64 | Store data |
| cpu_req_be | input | 8 | Store byte enables |
| cpu_ready | output | 1 | Request accepted on this cycle if valid |
| cpu_resp_valid | output | 1 | Request completed |
| cpu_resp_rdata | output | 64 | Load data |
| mem_req_valid | output | 1 | Memory line request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_req_addr | output | 40 | Line-aligned memory address |
| mem_req_wdata | output | 512 | Write-back line data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 512 | Fetched line, valid with mem_ack |

## Verification
On every cycle, the bound checker checks the handshake and timing rules. A hit is answered on the next cycle with ready still high. A miss drops ready and gives no early response. Memory request fields hold steady until acknowledge. An acknowledged write-back is followed at once by a refill read. The response lands two cycles after the refill acknowledge. The assertions cannot see data or policy. The bench scenarios are what show correct byte merging, least-recently-used victim choice, invalid-way preference, clean-victim discard, and write-back contents that match every store made earlier. A reference memory, updated by the bench's own byte arithmetic, is the only source of expected values.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [1:0] {
      ST_LOOKUP = 2'd0,
      ST_WBACK  = 2'd1,
      ST_REFILL = 2'd2,
      ST_DONE   = 2'd3
   } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int SETS  = 512,
   parameter int IDX_W = 9,
   parameter int TAG_W = 25
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W-1:0]       idx,
   input  logic [TAG_W-1:0]       look_tag,
   output logic [1:0]             hit_vec,
   output logic [1:0]             way_vld,
   output logic [1:0]             way_dty,
   output logic [1:0][TAG_W-1:0]  way_tag,
   output logic                   set_lru,
   input  logic                   touch_en,
   input  logic                   touch_way,
   input  logic                   dirty_en,
   input  logic                   dirty_way,
   input  logic                   fill_en,
   input  logic                   fill_way,
   input  logic [TAG_W-1:0]       fill_tag
);
   logic [1:0]       vld_q [SETS];
   logic [1:0]       dty_q [SETS];
   logic             lru_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][2];

   // state flags: cleared by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            dty_q[s] <= '0;
            lru_q[s] <= 1'b0;
         end
      end else begin
         if (fill_en) begin
            vld_q[idx][fill_way] <= 1'b1;
            dty_q[idx][fill_way] <= 1'b0;
         end
         if (dirty_en) dty_q[idx][dirty_way] <= 1'b1;
         if (touch_en) lru_q[idx] <= ~touch_way;
      end
   end

   // tags need no reset: guarded by valid flags
   always_ff @(posedge clk) begin
      if (fill_en) tag_q[idx][fill_way] <= fill_tag;
   end

   assign set_lru = lru_q[idx];

   for (genvar w = 0; w < 2; w++) begin : g_way
      assign way_vld[w] = vld_q[idx][w];
      assign way_dty[w] = dty_q[idx][w];
      assign way_tag[w] = tag_q[idx][w];
      assign hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == look_tag);
   end
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
   parameter int SETS   = 512,
   parameter int IDX_W  = 9,
   parameter int LINE_W = 512,
   parameter int WORD_W = 64,
   parameter int WSEL_W = 3
) (
   input  logic                  clk,
   input  logic [IDX_W-1:0]      idx,
   input  logic                  way,
   output logic [LINE_W-1:0]     rd_line,
   input  logic                  line_we,
   input  logic [LINE_W-1:0]     line_wdata,
   input  logic                  word_we,
   input  logic [WSEL_W-1:0]     word_sel,
   input  logic [WORD_W/8-1:0]   word_be,
   input  logic [WORD_W-1:0]     word_wdata
);
   localparam int NBYTE = WORD_W / 8;

   logic [LINE_W-1:0] mem_q [SETS*2];
   logic [IDX_W:0]    slot;

   assign slot    = {idx, way};
   assign rd_line = mem_q[slot];

   always_ff @(posedge clk) begin
      if (line_we) begin
         mem_q[slot] <= line_wdata;
      end else if (word_we) begin
         for (int b = 0; b < NBYTE; b++) begin
            if (word_be[b])
               mem_q[slot][(int'(word_sel) * NBYTE + b) * 8 +: 8] <= word_wdata[b*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
   import dc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      hit,
   input  logic      vic_dirty,
   input  logic      mem_ack,
   output dc_state_e state,
   output logic      cpu_ready,
   output logic      mem_req_valid,
   output logic      mem_req_write,
   output logic      latch_en,
   output logic      fill_en,
   output logic      serve_en
);
   dc_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_LOOKUP: if (req_valid && !hit) nxt = vic_dirty ? ST_WBACK : ST_REFILL;
         ST_WBACK:  if (mem_ack) nxt = ST_REFILL;
         ST_REFILL: if (mem_ack) nxt = ST_DONE;
         ST_DONE:   nxt = ST_LOOKUP;
         default:   nxt = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_LOOKUP;
      else        state <= nxt;
   end

   assign cpu_ready     = (state == ST_LOOKUP);
   assign mem_req_valid = (state == ST_WBACK) || (state == ST_REFILL);
   assign mem_req_write = (state == ST_WBACK);
   assign latch_en      = cpu_ready && req_valid && !hit;
   assign fill_en       = (state == ST_REFILL) && mem_ack;
   assign serve_en      = (cpu_ready && req_valid && hit) || (state == ST_DONE);
endmodule

// File: rtl/dcache2w.sv
module dcache2w
   import dc_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int LINE_BYTES = 64,
   parameter int WORD_BYTES = 8,
   parameter int SETS       = 512
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_req_valid,
   input  logic                      cpu_req_write,
   input  logic [ADDR_W-1:0]         cpu_req_addr,
   input  logic [WORD_BYTES*8-1:0]   cpu_req_wdata,
   input  logic [WORD_BYTES-1:0]     cpu_req_be,
   output logic                      cpu_ready,
   output logic                      cpu_resp_valid,
   output logic [WORD_BYTES*8-1:0]   cpu_resp_rdata,
   output logic                      mem_req_valid,
   output logic                      mem_req_write,
   output logic [ADDR_W-1:0]         mem_req_addr,
   output logic [LINE_BYTES*8-1:0]   mem_req_wdata,
   input  logic                      mem_ack,
   input  logic [LINE_BYTES*8-1:0]   mem_rdata
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int BYTE_W = $clog2(WORD_BYTES);
   localparam int WSEL_W = OFF_W - BYTE_W;
   localparam int WORD_W = WORD_BYTES * 8;
   localparam int LINE_W = LINE_BYTES * 8;

   if (SETS != (1 << IDX_W)) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (LINE_BYTES != (1 << OFF_W) || WORD_BYTES != (1 << BYTE_W)) begin : g_bad_bytes
      $error("line and word sizes must be powers of two");
   end
   if (WSEL_W < 1 || TAG_W < 1) begin : g_bad_split
      $error("address split leaves no tag or word select");
   end

   dc_state_e state;
   logic latch_en, fill_en, serve_en;

   // request register, used for the whole miss sequence
   logic [ADDR_W-1:0]     req_addr_q;
   logic                  req_write_q;
   logic [WORD_W-1:0]     req_wdata_q;
   logic [WORD_BYTES-1:0] req_be_q;

   always_ff @(posedge clk) begin
      if (latch_en) begin
         req_addr_q  <= cpu_req_addr;
         req_write_q <= cpu_req_write;
         req_wdata_q <= cpu_req_wdata;
         req_be_q    <= cpu_req_be;
      end
   end

   logic                  in_lookup;
   logic [ADDR_W-1:0]     lk_addr;
   logic                  lk_write;
   logic [WORD_W-1:0]     lk_wdata;
   logic [WORD_BYTES-1:0] lk_be;
   logic [IDX_W-1:0]      lk_idx;
   logic [TAG_W-1:0]      lk_tag;
   logic [WSEL_W-1:0]     lk_wsel;

   assign in_lookup = (state == ST_LOOKUP);
   assign lk_addr   = in_lookup ? cpu_req_addr  : req_addr_q;
   assign lk_write  = in_lookup ? cpu_req_write : req_write_q;
   assign lk_wdata  = in_lookup ? cpu_req_wdata : req_wdata_q;
   assign lk_be     = in_lookup ? cpu_req_be    : req_be_q;
   assign lk_idx    = lk_addr[OFF_W +: IDX_W];
   assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
   assign lk_wsel   = lk_addr[BYTE_W +: WSEL_W];

   logic [1:0]            hit_vec, way_vld, way_dty;
   logic [1:0][TAG_W-1:0] way_tag;
   logic                  set_lru, lk_hit, hit_way, vic_way, vic_dirty, acc_way;

   assign lk_hit    = |hit_vec;
   assign hit_way   = hit_vec[1];
   assign vic_way   = !way_vld[0] ? 1'b0 : (!way_vld[1] ? 1'b1 : set_lru);
   assign vic_dirty = way_vld[vic_way] && way_dty[vic_way];
   assign acc_way   = (state == ST_WBACK || state == ST_REFILL) ? vic_way : hit_way;

   dc_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (cpu_req_valid),
      .hit           (lk_hit),
      .vic_dirty     (vic_dirty),
      .mem_ack       (mem_ack),
      .state         (state),
      .cpu_ready     (cpu_ready),
      .mem_req_valid (mem_req_valid),
      .mem_req_write (mem_req_write),
      .latch_en      (latch_en),
      .fill_en       (fill_en),
      .serve_en      (serve_en)
   );

   dc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (lk_idx),
      .look_tag  (lk_tag),
      .hit_vec   (hit_vec),
      .way_vld   (way_vld),
      .way_dty   (way_dty),
      .way_tag   (way_tag),
      .set_lru   (set_lru),
      .touch_en  (serve_en || fill_en),
      .touch_way (fill_en ? vic_way : hit_way),
      .dirty_en  (serve_en && lk_write),
      .dirty_way (hit_way),
      .fill_en   (fill_en),
      .fill_way  (vic_way),
      .fill_tag  (lk_tag)
   );

   logic [LINE_W-1:0] rd_line;

   dc_data_store #(.SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W),
                   .WORD_W(WORD_W), .WSEL_W(WSEL_W)) u_data (
      .clk        (clk),
      .idx        (lk_idx),
      .way        (acc_way),
      .rd_line    (rd_line),
      .line_we    (fill_en),
      .line_wdata (mem_rdata),
      .word_we    (serve_en && lk_write),
      .word_sel   (lk_wsel),
      .word_be    (lk_be),
      .word_wdata (lk_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_resp_valid <= 1'b0;
      else        cpu_resp_valid <= serve_en;
   end

   always_ff @(posedge clk) begin
      if (serve_en && !lk_write)
         cpu_resp_rdata <= rd_line[int'(lk_wsel) * WORD_W +: WORD_W];
   end

   assign mem_req_addr  = {(state == ST_WBACK) ? way_tag[vic_way] : lk_tag,
                           lk_idx, {OFF_W{1'b0}}};
   assign mem_req_wdata = rd_line;
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
   parameter int ADDR_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_valid,
   input logic              cpu_ready,
   input logic              cpu_resp_valid,
   input logic              mem_req_valid,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_ack,
   input logic              lk_hit
);
   // R2: hit answered next cycle, port stays open
   a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && cpu_req_valid && lk_hit |=> cpu_resp_valid && cpu_ready);

   // R9: miss closes the port with no early answer
   a_r9_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && cpu_req_valid && !lk_hit |=> !cpu_ready && !cpu_resp_valid);

   // R9: no memory traffic while port is open
   a_r9_ready_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req_valid);

   // R11: request fields steady until acknowledge
   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

   // R7: write-back is followed by the refill read
   a_r7_wb_then_refill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write && mem_ack |=> mem_req_valid && !mem_req_write);

   // R12: response two cycles after refill acknowledge
   a_r12_refill_resp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_write && mem_ack |=> !cpu_ready ##1 cpu_resp_valid);
endmodule

bind dcache2w dc_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_req_valid  (cpu_req_valid),
   .cpu_ready      (cpu_ready),
   .cpu_resp_valid (cpu_resp_valid),
   .mem_req_valid  (mem_req_valid),
   .mem_req_write  (mem_req_write),
   .mem_req_addr   (mem_req_addr),
   .mem_ack        (mem_ack),
   .lk_hit         (lk_hit)
);

// File: tb/sim_dcache2w.sv
`timescale 1ns/1ps
module sim_dcache2w;
   localparam int AW = 40;
   localparam int LW = 512;
   localparam int WW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [WW-1:0] cpu_req_wdata = '0;
   logic [7:0]    cpu_req_be = '0;
   logic          cpu_ready, cpu_resp_valid;
   logic [WW-1:0] cpu_resp_rdata;
   logic          mem_req_valid, mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [LW-1:0] mem_req_wdata;
   logic          mem_ack = 1'b0;
   logic [LW-1:0] mem_rdata = '0;

   always #2 clk = ~clk;

   dcache2w u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
      .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
      .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0, fails = 0;
   int n_rd = 0, n_wr = 0, stab_bad = 0, rdy_bad = 0, dbl_resp = 0;
   int op_seq[$];
   logic [AW-1:0] last_wb_addr = '0;
   logic [LW-1:0] memstore [longint];
   logic [LW-1:0] shadow   [longint];

   function automatic logic [LW-1:0] line_init(longint la);
      logic [LW-1:0] v;
      for (int w = 0; w < 8; w++)
         v[w*64 +: 64] = {32'(la) ^ 32'h9E37_79B9, 32'(w) * 32'h0101_0101 + 32'h1357_2468};
      return v;
   endfunction

   function automatic logic [LW-1:0] sh_line(longint la);
      if (shadow.exists(la)) return shadow[la];
      return line_init(la);
   endfunction

   function automatic logic [LW-1:0] mem_line(longint la);
      if (memstore.exists(la)) return memstore[la];
      return line_init(la);
   endfunction

   function automatic logic [AW-1:0] mk_addr(int tag, int idx, int ws);
      return {25'(tag), 9'(idx), 3'(ws), 3'b000};
   endfunction

   function automatic longint line_of(logic [AW-1:0] a);
      return longint'(a >> 6);
   endfunction

   function automatic logic [WW-1:0] exp_word(logic [AW-1:0] a);
      logic [LW-1:0] l;
      l = sh_line(line_of(a));
      return l[int'(a[5:3]) * 64 +: 64];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // memory model with varying latency
   int dly = 0, lat = 1, lseed = 7;
   logic [AW-1:0] held_addr;
   logic          held_w;
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0; dly = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0; dly = 0;
      end else if (mem_req_valid) begin
         if (dly == 0) begin
            held_addr = mem_req_addr; held_w = mem_req_write;
         end else if (mem_req_addr != held_addr || mem_req_write != held_w) begin
            stab_bad++;
         end
         dly++;
         if (dly >= lat) begin
            if (mem_req_write) begin
               // R7 / R10: write-back carries the newest data of that line
               chk(mem_req_wdata == sh_line(line_of(mem_req_addr)), "R7 writeback data",
                   mem_req_wdata, sh_line(line_of(mem_req_addr)));
               memstore[line_of(mem_req_addr)] = mem_req_wdata;
               last_wb_addr = mem_req_addr;
               n_wr++;
               op_seq.push_back(1);
            end else begin
               mem_rdata = mem_line(line_of(mem_req_addr));
               n_rd++;
               op_seq.push_back(0);
            end
            mem_ack = 1'b1;
            lseed = (lseed * 13 + 5) % 97;
            lat = 1 + (lseed % 5);
         end
      end
   end

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [WW-1:0] wd,
                         input logic [7:0] be, output logic [WW-1:0] rd, output int cyc);
      logic [LW-1:0] l;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
      cpu_req_wdata = wd; cpu_req_be = be;
      while (!cpu_ready) @(negedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      cyc = 1;
      while (!cpu_resp_valid) begin
         if (cpu_ready) rdy_bad++;
         @(negedge clk);
         cyc++;
      end
      rd = cpu_resp_rdata;
      @(negedge clk);
      if (cpu_resp_valid) dbl_resp++;
      if (wr) begin
         l = sh_line(line_of(a));
         for (int b = 0; b < 8; b++)
            if (be[b]) l[int'(a[5:3]) * 64 + b*8 +: 8] = wd[b*8 +: 8];
         shadow[line_of(a)] = l;
      end
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input string req, output int cyc);
      logic [WW-1:0] r;
      access(1'b0, a, '0, '0, r, cyc);
      chk(r == exp_word(a), req, r, exp_word(a));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report();
   end

   initial begin
      logic [WW-1:0] r;
      int c, r0, w0;
      logic [7:0] bes [8];
      logic [AW-1:0] A, B, C, D, E, F;
      bes = '{8'h01, 8'h80, 8'hA5, 8'hFF, 8'h3C, 8'h00, 8'h0F, 8'hF0};
      A = mk_addr(1, 7, 0); B = mk_addr(2, 7, 0); C = mk_addr(3, 7, 0);
      D = mk_addr(4, 7, 2); E = mk_addr(5, 7, 0); F = mk_addr(6, 7, 0);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset state of the ports
      chk(cpu_ready && !cpu_resp_valid && !mem_req_valid, "R4 reset outputs",
          {cpu_ready, cpu_resp_valid, mem_req_valid}, 3'b100);

      // R4 R9: first access misses and fetches
      r0 = n_rd; w0 = n_wr;
      rd_chk(A, "R9 read miss data", c);
      chk(n_rd == r0 + 1 && n_wr == w0, "R4 first access fetches", n_rd - r0, 1);

      // R1 R2: every doubleword slot hits in one cycle
      r0 = n_rd;
      for (int ws = 0; ws < 8; ws++) begin
         rd_chk(mk_addr(1, 7, ws), "R1 doubleword select", c);
         chk(c == 1, "R2 hit latency", c, 1);
      end
      chk(n_rd == r0, "R2 hits issue no fetch", n_rd - r0, 0);

      // R3: byte-enable merges on write hits
      r0 = n_rd; w0 = n_wr;
      for (int ws = 0; ws < 8; ws++) begin
         access(1'b1, mk_addr(1, 7, ws), 64'hC0DE_0000_0000_0000 + 64'(ws) * 64'h1111_2222_3333, bes[ws], r, c);
         chk(c == 1, "R3 write hit latency", c, 1);
      end
      for (int ws = 0; ws < 8; ws++) rd_chk(mk_addr(1, 7, ws), "R3 merged bytes", c);
      chk(n_rd == r0 && n_wr == w0, "R3 write hits no memory", n_rd + n_wr - r0 - w0, 0);

      // R6: second tag fills the empty way, first line survives
      r0 = n_rd; w0 = n_wr;
      rd_chk(B, "R6 read B", c);
      chk(n_rd == r0 + 1 && n_wr == w0, "R6 no eviction into empty way", n_wr - w0, 0);
      rd_chk(A, "R6 A still resident", c);
      chk(c == 1, "R6 A hits", c, 1);

      // R8: third tag evicts clean B without write
      r0 = n_rd; w0 = n_wr;
      rd_chk(C, "R8 read C", c);
      chk(n_rd == r0 + 1 && n_wr == w0, "R8 clean victim discarded", n_wr - w0, 0);

      // R5: A was most recent, must still hit
      rd_chk(A, "R5 A kept", c);
      chk(c == 1, "R5 LRU kept recent way", c, 1);

      // R10: write miss allocates and merges
      r0 = n_rd; w0 = n_wr;
      access(1'b1, D, 64'hFEED_BEEF_1234_5678, 8'h0F, r, c);
      chk(n_rd == r0 + 1 && n_wr == w0, "R10 write miss allocates", n_rd - r0, 1);
      rd_chk(D, "R10 merged store", c);
      chk(c == 1, "R10 line now resident", c, 1);

      // R7: evicting dirty A writes it back before refill
      r0 = n_rd; w0 = n_wr;
      rd_chk(E, "R7 read E", c);
      chk(n_wr == w0 + 1 && n_rd == r0 + 1, "R7 one writeback one fetch", n_wr - w0, 1);
      chk(last_wb_addr == mk_addr(1, 7, 0), "R7 writeback address", last_wb_addr, mk_addr(1, 7, 0));
      chk(op_seq.size() >= 2 && op_seq[op_seq.size()-2] == 1 && op_seq[op_seq.size()-1] == 0,
          "R7 writeback precedes refill", op_seq[op_seq.size()-1], 0);

      // R10: dirty D evicted with merged data
      w0 = n_wr;
      rd_chk(F, "R10 read F", c);
      chk(n_wr == w0 + 1 && last_wb_addr == mk_addr(4, 7, 0), "R10 dirty store line written",
          last_wb_addr, mk_addr(4, 7, 0));
      rd_chk(D, "R10 refetched merged line", c);

      // R1: same tag, other index is a separate set
      r0 = n_rd;
      rd_chk(mk_addr(6, 8, 1), "R1 other set data", c);
      chk(n_rd == r0 + 1, "R1 other index misses", n_rd - r0, 1);

      // mixed sweep over three sets and three tags per set
      begin
         int s = 11;
         int sets [3] = '{0, 5, 511};
         for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            s = (s * 1103 + 12345) % 65521;
            a = mk_addr(3 + (s % 3), sets[(s / 3) % 3], (s / 9) % 8);
            if (i % 3 == 0)
               access(1'b1, a, {32'(s), 32'(i)}, 8'(s / 7), r, c);
            else
               rd_chk(a, "R1 sweep data", c);
         end
      end

      chk(stab_bad == 0, "R11 memory request held", stab_bad, 0);
      chk(rdy_bad == 0, "R9 ready low during miss", rdy_bad, 0);
      chk(dbl_resp == 0, "R12 single response pulse", dbl_resp, 0);
      report();
   end
endmodule